// File: doc/BRIEF.md
# Majority-Vote Bit-Serial Adder

This block adds two unsigned operands that arrive one bit per beat, least significant bit first. It uses a single full-adder cell for the whole word. Both the sum and the carry of that cell come only from three-input majority votes and inverters; the block has no XOR or AND gates. The carry-out of each beat is stored in a register, and that register is the carry-in of the next beat. A word of any length is therefore added over as many beats as it has bits. A start flag that arrives with the first bit forces the carry-in of that bit to zero.

The carry is always the majority of the two operand bits and the carry-in. The sum can be built in two ways, selected at build time by the parameter `SUM_FORM`. With `SUM_FORM = 0` it is a vote over three inner votes, each with one input inverted. With `SUM_FORM = 1` it uses fewer gates: a vote of the inverted carry-out, the carry-in, and one inner vote whose carry-in is inverted. Both settings give the same results.

Input beats use a valid/ready handshake. A beat is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high when the output register is empty or is being drained in the same cycle, so back-pressure on `sum_ready` stops intake at once. The output register holds its sum bit until it is taken.

Top module: `maj_serial_adder`

## Requirements
- R1: On an accepted beat the stored carry becomes the majority of `a_bit`, `b_bit` and the carry-in. The carry-in is 0 when `start` is high and is the stored carry otherwise. `carry_out` shows the stored carry.
- R2: The sum bit of an accepted beat equals the modulo-2 sum of `a_bit`, `b_bit` and the carry-in, for both `SUM_FORM` settings (0 = vote of three votes, 1 = reduced vote that reuses the carry).
- R3: `sum_valid` and `sum_bit` change one clock edge after the beat is accepted.
- R4: A word of N bits, sent least significant bit first with `start` on bit 0 only, gives on `sum_bit` the N low bits of the integer sum. After the last beat, `carry_out` equals bit N of that sum.
- R5: On a cycle with no accepted beat the stored carry does not change. If `sum_ready` is high on that cycle, `sum_valid` goes low.
- R6: While `sum_valid` is high and `sum_ready` is low, `in_ready` is low and `sum_valid`, `sum_bit` and `carry_out` keep their values.
- R7: `start` has no effect while `in_valid` is low. A later beat without `start` still uses the held carry.
- R8: During reset `sum_valid` is 0 and the stored carry is 0. `in_ready` is 1 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An input beat is present |
| in_ready | output | 1 | The block can accept a beat |
| a_bit | input | 1 | Bit of operand A for this beat |
| b_bit | input | 1 | Bit of operand B for this beat |
| start | input | 1 | First bit of a word; sets the carry-in to zero |
| sum_valid | output | 1 | `sum_bit` holds a result |
| sum_ready | input | 1 | The consumer takes the result |
| sum_bit | output | 1 | Registered sum bit |
| carry_out | output | 1 | Stored carry after the last accepted beat |

## Verification
The case hardest to reach is a word that is stalled partway through. The carry has to survive idle cycles, a stray `start` with no valid, and a blocked output, all without changing. The bench first ends a word with a carry of 1. It then inserts idle cycles and a lone `start`, and sends an all-zero beat without `start`; the carry of 1 must appear as the sum bit. Back-pressure is tested by holding `sum_ready` low while a second beat waits at the input. Both `SUM_FORM` settings are built side by side and receive the same stimulus.

// File: rtl/maj_add_pkg.sv
package maj_add_pkg;
  // build-time choice of the sum network
  localparam int FORM_TRIPLE = 0;  // vote of three one-inverted votes
  localparam int FORM_REUSE  = 1;  // reduced form sharing the carry vote

  typedef struct packed {
    logic sum;
    logic carry;
  } fa_out_t;
endpackage

// File: rtl/maj_vote3.sv
module maj_vote3 (
  input  logic x,
  input  logic y,
  input  logic z,
  output logic m
);
  assign m = (x & y) | (x & z) | (y & z);
endmodule

// File: rtl/maj_full_adder.sv
module maj_full_adder
  import maj_add_pkg::*;
#(
  parameter int SUM_FORM = FORM_TRIPLE
) (
  input  logic    a,
  input  logic    b,
  input  logic    cin,
  output fa_out_t res
);
  logic cy;
  logic sm;

  // carry: plain vote of the three inputs
  maj_vote3 u_carry_vote (.x(a), .y(b), .z(cin), .m(cy));

  generate
    if (SUM_FORM == FORM_TRIPLE) begin : g_triple
      logic a_n, b_n, c_n;
      logic v_a, v_b, v_c;
      assign a_n = ~a;
      assign b_n = ~b;
      assign c_n = ~cin;
      maj_vote3 u_va (.x(a_n), .y(b),   .z(cin), .m(v_a));
      maj_vote3 u_vb (.x(a),   .y(b_n), .z(cin), .m(v_b));
      maj_vote3 u_vc (.x(a),   .y(b),   .z(c_n), .m(v_c));
      maj_vote3 u_vs (.x(v_a), .y(v_b), .z(v_c), .m(sm));
    end else begin : g_reuse
      logic c_n, cy_n, v_p;
      assign c_n  = ~cin;
      assign cy_n = ~cy;
      maj_vote3 u_vp (.x(a),    .y(b),   .z(c_n), .m(v_p));
      maj_vote3 u_vs (.x(cy_n), .y(cin), .z(v_p), .m(sm));
    end
  endgenerate

  assign res.sum   = sm;
  assign res.carry = cy;
endmodule

// File: rtl/maj_carry_loop.sv
module maj_carry_loop (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic first,
  input  logic cy_next,
  output logic cin_eff,
  output logic cy_q
);
  // first bit of a word sees a zero carry-in
  assign cin_eff = first ? 1'b0 : cy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cy_q <= 1'b0;
    else if (take) cy_q <= cy_next;
  end
endmodule

// File: rtl/maj_out_stage.sv
module maj_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic drain,
  input  logic sum_in,
  output logic busy,
  output logic sum_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      sum_q <= 1'b0;
    end else if (take) begin
      busy  <= 1'b1;
      sum_q <= sum_in;
    end else if (drain) begin
      busy  <= 1'b0;
    end
  end
endmodule

// File: rtl/maj_serial_adder.sv
module maj_serial_adder
  import maj_add_pkg::*;
#(
  parameter int SUM_FORM = FORM_TRIPLE
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  input  logic a_bit,
  input  logic b_bit,
  input  logic start,
  output logic sum_valid,
  input  logic sum_ready,
  output logic sum_bit,
  output logic carry_out
);
  logic    accept;
  logic    cin_eff;
  logic    cy_q;
  logic    busy;
  fa_out_t fa;

  assign in_ready = !busy || sum_ready;
  assign accept   = in_valid && in_ready;

  maj_full_adder #(.SUM_FORM(SUM_FORM)) u_fa (
    .a(a_bit), .b(b_bit), .cin(cin_eff), .res(fa)
  );

  maj_carry_loop u_loop (
    .clk(clk), .rst_n(rst_n), .take(accept), .first(start),
    .cy_next(fa.carry), .cin_eff(cin_eff), .cy_q(cy_q)
  );

  maj_out_stage u_out (
    .clk(clk), .rst_n(rst_n), .take(accept), .drain(sum_ready),
    .sum_in(fa.sum), .busy(busy), .sum_q(sum_bit)
  );

  assign sum_valid = busy;
  assign carry_out = cy_q;
endmodule

// File: rtl/maj_serial_adder_chk.sv
module maj_serial_adder_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic a_bit,
  input logic b_bit,
  input logic start,
  input logic sum_valid,
  input logic sum_ready,
  input logic sum_bit,
  input logic carry_out
);
  // R8
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (!sum_valid && !carry_out));

  // R1
  start_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && start) |=> carry_out == ($past(a_bit) & $past(b_bit)));

  // R2
  sum_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=>
      sum_bit == ($past(a_bit) ^ $past(b_bit) ^ ($past(start) ? 1'b0 : $past(carry_out))));

  // R3
  out_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> sum_valid);

  // R5
  carry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> $stable(carry_out));

  // R6
  stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sum_valid && !sum_ready) |-> !in_ready);

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sum_valid && !sum_ready) |=> (sum_valid && $stable(sum_bit) && $stable(carry_out)));
endmodule

bind maj_serial_adder maj_serial_adder_chk u_chk (.*);

// File: tb/maj_serial_adder_bench.sv
module maj_serial_adder_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic a_bit = 1'b0;
  logic b_bit = 1'b0;
  logic start = 1'b0;
  logic sum_ready = 1'b1;

  logic rdy0, sv0, sb0, co0;
  logic rdy1, sv1, sb1, co1;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  maj_serial_adder #(.SUM_FORM(0)) u_maj_serial_adder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy0),
    .a_bit(a_bit), .b_bit(b_bit), .start(start), .sum_valid(sv0),
    .sum_ready(sum_ready), .sum_bit(sb0), .carry_out(co0)
  );

  maj_serial_adder #(.SUM_FORM(1)) u_maj_serial_adder_alt (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy1),
    .a_bit(a_bit), .b_bit(b_bit), .start(start), .sum_valid(sv1),
    .sum_ready(sum_ready), .sum_bit(sb1), .carry_out(co1)
  );

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // one beat: drive at the falling edge, sample just after the rising edge
  task automatic beat(logic v, logic a, logic b, logic st);
    @(negedge clk);
    in_valid = v; a_bit = a; b_bit = b; start = st;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R8
    chk("R8", "sum_valid form0", sv0, 1'b0);
    chk("R8", "sum_valid form1", sv1, 1'b0);
    chk("R8", "carry form0", co0, 1'b0);
    chk("R8", "carry form1", co1, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R8", "in_ready", rdy0 & rdy1, 1'b1);
  endtask

  task automatic t_word(int n, logic [31:0] a, logic [31:0] b);
    logic [32:0] full;
    logic [31:0] mask;
    mask = (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
    full = {1'b0, a & mask} + {1'b0, b & mask};
    for (int i = 0; i < n; i++) begin
      beat(1'b1, a[i], b[i], i == 0);
      // R3: result one edge after acceptance
      chk("R3", "sum_valid", sv0 & sv1, 1'b1);
      // R4 / R2: both formulations match the integer sum
      chk("R4", "sum bit form0", sb0, full[i]);
      chk("R2", "sum bit form1", sb1, full[i]);
    end
    // R1 / R4: final carry
    chk("R4", "final carry form0", co0, full[n]);
    chk("R1", "final carry form1", co1, full[n]);
  endtask

  task automatic t_idle_and_stray_start();
    // ends with carry 1: 0xFF + 0x01 over 8 bits
    t_word(8, 32'hFF, 32'h01);
    // R5: idle cycle drops sum_valid, holds carry
    beat(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R5", "sum_valid idle", sv0 | sv1, 1'b0);
    chk("R5", "carry held", co0 & co1, 1'b1);
    // R7: start without valid is ignored
    beat(1'b0, 1'b0, 1'b0, 1'b1);
    chk("R7", "carry after stray start", co0 & co1, 1'b1);
    beat(1'b1, 1'b0, 1'b0, 1'b0);
    chk("R7", "sum uses held carry f0", sb0, 1'b1);
    chk("R7", "sum uses held carry f1", sb1, 1'b1);
    chk("R1", "carry cleared", co0 | co1, 1'b0);
    beat(1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    sum_ready = 1'b0;
    beat(1'b1, 1'b1, 1'b1, 1'b1);  // 1+1, carry-in 0 -> sum 0 carry 1
    chk("R6", "held sum", sb0 | sb1, 1'b0);
    chk("R6", "in_ready low", rdy0 | rdy1, 1'b0);
    beat(1'b1, 1'b0, 1'b0, 1'b0);  // waits at input
    chk("R6", "sum_valid held", sv0 & sv1, 1'b1);
    chk("R6", "sum still old", sb0 | sb1, 1'b0);
    chk("R6", "carry unchanged", co0 & co1, 1'b1);
    @(negedge clk);
    sum_ready = 1'b1;
    #1;
    chk("R6", "in_ready on drain", rdy0 & rdy1, 1'b1);
    @(posedge clk);
    #1;
    // pending beat 0+0 with carry 1 -> sum 1, carry 0
    chk("R6", "new sum after drain f0", sb0, 1'b1);
    chk("R2", "new sum after drain f1", sb1, 1'b1);
    chk("R1", "carry after drain", co0 | co1, 1'b0);
    beat(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R5", "drained", sv0 | sv1, 1'b0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        checks++;
        $display("FAIL R4 watchdog: actual=%0d cycles expected<=100000", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    t_reset();
    t_word(1, 32'h1, 32'h1);
    t_word(4, 32'h5, 32'hA);
    t_word(32, 32'hFFFF_FFFF, 32'h0000_0001);
    t_word(16, 32'h1234, 32'hEDCC);
    for (int k = 0; k < 40; k++) begin
      int n;
      n = 1 + int'($urandom_range(31, 0));
      t_word(n, $urandom, $urandom);
      if (k % 5 == 0) beat(1'b0, 1'b0, 1'b0, 1'b0);
    end
    t_idle_and_stray_start();
    t_backpressure();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule